// File: doc/BRIEF.md
# Walking-Bit Cable Test Sequencer

This block drives a parallel data port in a wiring-check mode. A host talks to it over a toggle handshake. Every level change on the request input counts as one request, and the block answers each request by flipping its strobe output once. When the restart input goes high, the block arms the test and answers with a single strobe flip, but it leaves the port at zero. From then on, each request moves one asserted bit up the data lines, starting at the lowest line and ending at the highest. The next two requests return a version code, high byte first. After that, the port stays at zero and every further request still gets its strobe flip.

All timing is counted in ticks of a clock-enable input. New data is placed on the port a setup interval before the strobe flip, and the strobe answers a request within a response interval. Both intervals are parameters. The block drives no data before a request. Its output enable is high only while the unit is selected and the test is armed, so several units can share one bus as long as the host addresses one unit at a time. Request and restart inputs pass through a synchronizer. A request that arrives while an earlier one is still being served is held and served afterwards.

Top module: `cable_test_seq`

## Requirements
- R1: After reset, strobe_o, data_o and data_oe_o are all low.
- R2: A rising restart_i arms the test. After SETUP_TICKS ticks, plus at most one tick of synchronizer latency, strobe_o flips once, and data_o stays all zeros.
- R3: After arming, request number k (k = 1..DATA_W) drives data_o with only bit k-1 set. Bit 0 is set by the first request and the highest bit by request DATA_W.
- R4: Every request served produces exactly one strobe_o flip. The strobe never flips except to acknowledge a restart or a request.
- R5: Request DATA_W+1 returns VERSION[2*DATA_W-1:DATA_W] and request DATA_W+2 returns VERSION[DATA_W-1:0].
- R6: Every request after the version low byte returns all zeros on data_o and still flips strobe_o.
- R7: When a request changes data_o, the new value is on the port at least SETUP_TICKS ticks before the strobe flip. The flip itself comes between RESP_TICKS and RESP_TICKS+1 ticks after the request edge.
- R8: data_oe_o is high only while sel_i is high and the test is armed. It follows sel_i with one clock of latency.
- R9: While restart_i is low, the block stays idle. data_o is zero, data_oe_o is low, and request changes do not flip strobe_o. A new restart starts the sequence again from bit 0.
- R10: A request that arrives while an earlier one is being served is held. It is then served with its own strobe flip and the next step's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Clock-enable tick that paces all intervals |
| sel_i | input | 1 | Unit selected on the shared bus |
| restart_i | input | 1 | Arms the test while high (asynchronous) |
| adr_req_i | input | 1 | Toggle request line (asynchronous) |
| data_o | output | DATA_W | Test pattern or version byte |
| data_oe_o | output | 1 | Enable for the external data port driver |
| strobe_o | output | 1 | Toggle acknowledge line |

## Verification
If the step counter is wrong, the very next acknowledged request shows a misplaced bit, a wrong version byte, or a zero at the wrong point, so the fault appears within one request. If the interval timer is wrong, the tick count between the request edge and the strobe flip changes, or the data lands too close to the flip, and this is measured on every step. If the held-request flag is lost, a second request made during service gets no strobe flip, and the bench detects that within one response interval. If state leaks across a restart, it shows up at the first request after re-arming, which must set bit 0 again.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_READY,
    ST_LEAD,
    ST_SETTLE
  } cts_state_e;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cts_tick_timer.sv
module cts_tick_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i)             cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // Expires on the tick that consumes the last count.
  assign expire_o = tick_i && (cnt_q == CNT_W'(1));

  assert_load_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (load_val_i != '0));

  assert_count_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i && !clear_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/cts_pattern.sv
module cts_pattern #(
  parameter int                  DATA_W  = 8,
  parameter int                  STEP_W  = 4,
  parameter logic [2*DATA_W-1:0] VERSION = '0
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [DATA_W-1:0] pat_o
);
  localparam logic [STEP_W-1:0] STEP_VER_HI = STEP_W'(DATA_W + 1);
  localparam logic [STEP_W-1:0] STEP_VER_LO = STEP_W'(DATA_W + 2);

  logic [DATA_W-1:0] walk;

  for (genvar g = 0; g < DATA_W; g++) begin : g_walk
    assign walk[g] = (step_i == STEP_W'(g + 1));
  end

  always_comb begin
    if (|walk)                       pat_o = walk;
    else if (step_i == STEP_VER_HI)  pat_o = VERSION[2*DATA_W-1:DATA_W];
    else if (step_i == STEP_VER_LO)  pat_o = VERSION[DATA_W-1:0];
    else                             pat_o = '0;
  end
endmodule

// File: rtl/cable_test_seq.sv
module cable_test_seq
  import cts_pkg::*;
#(
  parameter int                  DATA_W      = 8,
  parameter int                  SETUP_TICKS = 6,
  parameter int                  RESP_TICKS  = 15,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [2*DATA_W-1:0] VERSION     = 16'h0102
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              restart_i,
  input  logic              adr_req_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              strobe_o
);
  localparam int STEP_W = $clog2(DATA_W + 4);
  localparam int CNT_W  = $clog2(RESP_TICKS + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(DATA_W + 3);
  localparam logic [CNT_W-1:0]  SETUP_VAL = CNT_W'(SETUP_TICKS);
  localparam logic [CNT_W-1:0]  LEAD_VAL  = CNT_W'(RESP_TICKS - SETUP_TICKS);

  logic              restart_s, adr_s, adr_d;
  logic              adr_chg;
  cts_state_e        state_q;
  logic [STEP_W-1:0] step_q, step_nxt;
  logic [DATA_W-1:0] data_q, pat;
  logic              strobe_q, oe_q, pend_q;
  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;

  cts_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({restart_i, adr_req_i}),
    .q_o ({restart_s, adr_s})
  );

  cts_tick_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (!restart_s),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .tick_i     (tick_i),
    .expire_o   (tmr_exp)
  );

  assign step_nxt = (step_q == STEP_LAST) ? step_q : step_q + 1'b1;

  cts_pattern #(.DATA_W(DATA_W), .STEP_W(STEP_W), .VERSION(VERSION)) pat_i (
    .step_i (step_nxt),
    .pat_o  (pat)
  );

  assign adr_chg = adr_s ^ adr_d;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = SETUP_VAL;
    if (restart_s) begin
      unique case (state_q)
        ST_IDLE:  tmr_load = 1'b1;
        ST_READY: if (adr_chg || pend_q) begin
                    tmr_load = 1'b1;
                    tmr_val  = LEAD_VAL;
                  end
        ST_LEAD:  tmr_load = tmr_exp;
        default:  tmr_load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_d    <= 1'b0;
      state_q  <= ST_IDLE;
      step_q   <= '0;
      data_q   <= '0;
      strobe_q <= 1'b0;
      oe_q     <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      adr_d <= adr_s;
      oe_q  <= sel_i && (state_q != ST_IDLE) && restart_s;
      if (!restart_s) begin
        state_q <= ST_IDLE;
        step_q  <= '0;
        data_q  <= '0;
        pend_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: state_q <= ST_ARM;
          ST_ARM: begin
            if (adr_chg) pend_q <= 1'b1;
            if (tmr_exp) begin
              strobe_q <= ~strobe_q;
              state_q  <= ST_READY;
            end
          end
          ST_READY: begin
            if (adr_chg || pend_q) begin
              pend_q  <= adr_chg & pend_q;
              state_q <= ST_LEAD;
            end
          end
          ST_LEAD: begin
            if (adr_chg) pend_q <= 1'b1;
            if (tmr_exp) begin
              step_q  <= step_nxt;
              data_q  <= pat;
              state_q <= ST_SETTLE;
            end
          end
          ST_SETTLE: begin
            if (adr_chg) pend_q <= 1'b1;
            if (tmr_exp) begin
              strobe_q <= ~strobe_q;
              state_q  <= ST_READY;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;
  assign strobe_o  = strobe_q;

  assert_strobe_source_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe_q != $past(strobe_q)) |->
      ($past(state_q) == ST_ARM || $past(state_q) == ST_SETTLE));

  assert_walk_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READY && step_q >= STEP_W'(1) && step_q <= STEP_W'(DATA_W))
      |-> ($countones(data_q) == 1));

  assert_tail_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (step_q == STEP_LAST) |-> (data_q == '0));

  assert_settle_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE && $past(state_q) == ST_SETTLE) |-> $stable(data_q));

  assert_oe_needs_sel_R8: assert property (@(posedge clk) disable iff (rst)
    !sel_i |=> !data_oe_o);

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (data_q == '0 && !pend_q));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> $stable(strobe_q));
endmodule

// File: tb/cable_test_seq_tb_top.sv
module cable_test_seq_tb_top;
  localparam int          DW    = 8;
  localparam int          SETUP = 3;
  localparam int          RESP  = 7;
  localparam logic [15:0] VER   = 16'hA53C;

  logic          clk = 1'b0;
  logic          rst, tick_i, sel_i, restart_i, adr_req_i;
  logic [DW-1:0] data_o;
  logic          data_oe_o, strobe_o;
  int            checks = 0, failures = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  cable_test_seq #(
    .DATA_W(DW), .SETUP_TICKS(SETUP), .RESP_TICKS(RESP),
    .SYNC_STAGES(2), .VERSION(VER)
  ) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .sel_i(sel_i),
    .restart_i(restart_i), .adr_req_i(adr_req_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .strobe_o(strobe_o)
  );

  initial begin
    tick_i = 1'b0;
    forever begin
      repeat (3) @(posedge clk);
      tick_i <= 1'b1;
      @(posedge clk);
      tick_i <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Wait for a strobe flip; counts ticks and the tick index of a data change.
  task automatic wait_flip(output bit seen, output int ticks, output int dtick);
    logic s0 = strobe_o;
    logic [DW-1:0] d0 = data_o;
    ticks = 0; dtick = -1; seen = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (tick_i) ticks++;
      if (data_o != d0 && dtick < 0) dtick = ticks;
      if (strobe_o != s0) begin seen = 1'b1; break; end
    end
  endtask

  task automatic do_step(input logic [DW-1:0] exp, input string req);
    bit seen; int t, dt;
    @(negedge clk) adr_req_i = ~adr_req_i;
    wait_flip(seen, t, dt);
    chk(seen, "R4", {req, " strobe flip"}, seen, 1);
    chk(data_o == exp, req, "data at strobe", data_o, exp);
    chk(t >= RESP && t <= RESP + 1, "R7", "response ticks", t, RESP);
    if (dt >= 0) chk(t - dt >= SETUP, "R7", "setup ticks", t - dt, SETUP);
  endtask

  task automatic t_reset;
    rst = 1'b1; sel_i = 1'b1; restart_i = 1'b0; adr_req_i = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk(strobe_o == 1'b0, "R1", "strobe after reset", strobe_o, 0);
    chk(data_o == '0, "R1", "data after reset", data_o, 0);
    chk(data_oe_o == 1'b0, "R1", "oe after reset", data_oe_o, 0);
  endtask

  task automatic t_idle_ignore;
    logic s0 = strobe_o;
    @(negedge clk) adr_req_i = ~adr_req_i;
    repeat (100) @(negedge clk);
    chk(strobe_o == s0, "R9", "strobe idle", strobe_o, s0);
    chk(data_oe_o == 1'b0, "R9", "oe idle", data_oe_o, 0);
    chk(data_o == '0, "R9", "data idle", data_o, 0);
  endtask

  task automatic t_arm;
    bit seen; int t, dt;
    @(negedge clk) restart_i = 1'b1;
    wait_flip(seen, t, dt);
    chk(seen, "R2", "arm strobe", seen, 1);
    chk(t >= SETUP && t <= SETUP + 1, "R2", "arm ticks", t, SETUP);
    chk(data_o == '0, "R2", "data after arm", data_o, 0);
    @(negedge clk);
    chk(data_oe_o == 1'b1, "R8", "oe armed+selected", data_oe_o, 1);
  endtask

  task automatic t_walk;
    for (int i = 0; i < DW; i++) do_step(DW'(1) << i, "R3");
  endtask

  task automatic t_version_and_tail;
    do_step(VER[15:8], "R5");
    do_step(VER[7:0], "R5");
    do_step('0, "R6");
    do_step('0, "R6");
  endtask

  task automatic t_deselect;
    @(negedge clk) sel_i = 1'b0;
    @(negedge clk);
    chk(data_oe_o == 1'b0, "R8", "oe deselected", data_oe_o, 0);
    @(negedge clk) sel_i = 1'b1;
    @(negedge clk);
    chk(data_oe_o == 1'b1, "R8", "oe reselected", data_oe_o, 1);
  endtask

  task automatic t_restart_drop;
    logic s0;
    @(negedge clk) restart_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(data_oe_o == 1'b0, "R9", "oe after drop", data_oe_o, 0);
    s0 = strobe_o;
    @(negedge clk) adr_req_i = ~adr_req_i;
    repeat (80) @(negedge clk);
    chk(strobe_o == s0, "R9", "no strobe while idle", strobe_o, s0);
  endtask

  task automatic t_pending;
    bit seen; int t, dt;
    @(negedge clk) adr_req_i = ~adr_req_i;
    repeat (12) @(negedge clk);
    adr_req_i = ~adr_req_i;
    wait_flip(seen, t, dt);
    chk(seen && data_o == DW'(1), "R10", "first served (rearm from bit0, R9)", data_o, 1);
    wait_flip(seen, t, dt);
    chk(seen, "R10", "held request flip", seen, 1);
    chk(data_o == DW'(2), "R10", "held request data", data_o, 2);
  endtask

  initial begin
    t_reset();
    t_idle_ignore();
    t_arm();
    t_walk();
    t_version_and_tail();
    t_deselect();
    t_restart_drop();
    t_arm();
    t_pending();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule